// File: doc/BRIEF.md
# Region-Based Memory Access Firewall

This block sits between an initiator request port and a memory target port. It checks every read or write request against windows that software programs, then either forwards the request to the target or stops it at the boundary. Requests marked secure always go through. A non-secure request goes through only when its address falls inside an enabled window of the bank that matches its initiator class. There is one bank of windows for processor-class initiators and one for all other requesters, such as DMA engines or network controllers.

A stopped request never reaches the target port. The firewall accepts it and answers it locally. One cycle after acceptance it raises an error response on a separate response port. A read error carries pseudo-random data from a free-running LFSR, and a write error carries zero data. Windows have 64 KiB granularity over a 37-bit address space. Software programs them, and their enable bits, through a small word-addressed register port. The enable bits can be reached through a direct register, a write-one-to-set register and a write-one-to-clear register.

Top module: `mem_fw_gate`

## Requirements
- R1: After reset every window enable bit is 0, no error response is pending, and a non-secure request to any address is blocked.
- R2: A request with `rq_secure`=1 is always forwarded: `tg_valid` equals `rq_valid`, and address, write flag, secure bit and write data appear unchanged on the target port in the same cycle.
- R3: A non-secure request is forwarded when some enabled window satisfies base ≤ addr[36:16] ≤ limit, with both ends inclusive. Address bits [15:0] take no part in the comparison. Otherwise the request is blocked.
- R4: `rq_cpu`=1 selects the processor bank, whose enables are bits [7:0] with bit n for window n. `rq_cpu`=0 selects the other bank, whose enables are bits [15:8] with bit 8+n for window n. Windows in the unselected bank have no effect.
- R5: A blocked request never asserts `tg_valid`, not even for one cycle.
- R6: A blocked request is accepted when no error response is pending or the pending one is being taken. `er_valid` rises on the next clock edge with `er_write` echoing the request. While `er_ready` is 0 the response holds stable and further blocked requests see `rq_ready`=0.
- R7: A read error response carries non-zero pseudo-random data that differs between successive responses. A write error response carries zero data.
- R8: Config word address 0 is the enable register. Its bits [15:0] are written and read back directly, and bits [31:16] read as 0.
- R9: Writing address 1 ORs the written bits into the enables. Writing address 2 clears the enables whose written bits are 1. Bits written as 0 to either register change nothing. Reading address 1 or 2 returns the enables.
- R10: Window registers sit at word address 16 + 32·bank + 4·window + field, where bank 0 is the processor bank. The fields are 0 base low, 1 base extension, 2 limit low and 3 limit extension. A low register holds address bits [31:16] in bits [31:16] and reads 0 in bits [15:0]. An extension register holds address bits [36:32] in bits [4:0].
- R11: For a request that is forwarded, `rq_ready` follows `tg_ready` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 1 | Request valid from initiator |
| rq_ready | output | 1 | Request accepted (forwarded or answered locally) |
| rq_addr | input | 37 | Request byte address |
| rq_write | input | 1 | 1 = write, 0 = read |
| rq_secure | input | 1 | Protection secure attribute |
| rq_cpu | input | 1 | Initiator class: 1 = processor, 0 = other |
| rq_wdata | input | 32 | Write data |
| tg_valid | output | 1 | Request valid towards target |
| tg_ready | input | 1 | Target ready |
| tg_addr | output | 37 | Forwarded address |
| tg_write | output | 1 | Forwarded write flag |
| tg_secure | output | 1 | Forwarded secure attribute |
| tg_wdata | output | 32 | Forwarded write data |
| er_valid | output | 1 | Local error response valid |
| er_ready | input | 1 | Initiator takes error response |
| er_write | output | 1 | Error response belongs to a write |
| er_rdata | output | 32 | Error response data (random for reads, zero for writes) |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 7 | Config word address |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data (combinational) |

## Verification
A table of requests is sent after one window is programmed in each bank. Each entry pairs an address with a secure bit, an initiator class and a read/write flag. Addresses placed exactly on a base, exactly on a limit, one page beyond a limit and one byte below a base tell an inclusive comparison from an exclusive or off-by-one one. Sending the same address with each initiator class shows that the bank is chosen by class. Secure entries outside every window show that the secure bypass is independent of the windows. Directed sequences cover the remaining behaviour: zero writes to the set and clear registers, clearing a window so that a former hit is blocked, target backpressure, and error responses held under `er_ready`=0 with a second blocked request stalled behind them.

// File: rtl/mem_fw_pkg.sv
package mem_fw_pkg;

   // config word addresses of the enable views
   localparam int unsigned REG_EN   = 0;
   localparam int unsigned REG_SET  = 1;
   localparam int unsigned REG_CLR  = 2;
   // first word of the window register block
   localparam int unsigned WIN_BASE = 16;

   // bank indices, selected by initiator class
   localparam int unsigned NUM_BANK   = 2;
   localparam int unsigned BANK_CPU   = 0;
   localparam int unsigned BANK_OTHER = 1;

   typedef enum logic [1:0] {
      FLD_BASE_LO = 2'd0,
      FLD_BASE_HI = 2'd1,
      FLD_LIM_LO  = 2'd2,
      FLD_LIM_HI  = 2'd3
   } win_fld_e;

endpackage

// File: rtl/mem_fw_lfsr.sv
module mem_fw_lfsr #(
   parameter int unsigned        W    = 32,
   parameter logic [W-1:0]       POLY = 32'h8020_0003,
   parameter logic [W-1:0]       SEED = 32'h1ACE_B00C
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);

   if (SEED == '0) begin : g_bad_seed
      $error("mem_fw_lfsr: SEED must be non-zero");
   end
   if (W < 3) begin : g_bad_width
      $error("mem_fw_lfsr: W too small");
   end

   // Galois form, shifting right; advances every cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (state[0]) begin
         state <= (state >> 1) ^ POLY;
      end else begin
         state <= state >> 1;
      end
   end

endmodule

// File: rtl/mem_fw_bank.sv
module mem_fw_bank #(
   parameter int unsigned NW = 8,
   parameter int unsigned PW = 21
) (
   input  logic [NW-1:0]         en,
   input  logic [NW-1:0][PW-1:0] base,
   input  logic [NW-1:0][PW-1:0] lim,
   input  logic [PW-1:0]         pg,
   output logic                  hit
);

   logic [NW-1:0] match;

   for (genvar w = 0; w < NW; w++) begin : g_win
      // inclusive on both ends
      assign match[w] = en[w] && (base[w] <= pg) && (pg <= lim[w]);
   end

   assign hit = |match;

endmodule

// File: rtl/mem_fw_regs.sv
module mem_fw_regs
   import mem_fw_pkg::*;
#(
   parameter int unsigned NW     = 8,
   parameter int unsigned ADDR_W = 37,
   parameter int unsigned GRAN   = 16,
   parameter int unsigned CFG_AW = 7,
   localparam int unsigned PW    = ADDR_W - GRAN,
   localparam int unsigned EN_W  = NUM_BANK * NW
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_wr,
   input  logic [CFG_AW-1:0]                  cfg_addr,
   input  logic [31:0]                        cfg_wdata,
   output logic [31:0]                        cfg_rdata,
   output logic [EN_W-1:0]                    en_o,
   output logic [NUM_BANK-1:0][NW-1:0][PW-1:0] base_o,
   output logic [NUM_BANK-1:0][NW-1:0][PW-1:0] lim_o
);

   localparam int unsigned LO_W  = 32 - GRAN;
   localparam int unsigned HI_W  = ADDR_W - 32;
   localparam int unsigned WB    = (NW > 1) ? $clog2(NW) : 1;
   localparam int unsigned IDX_W = WB + 3;
   localparam int unsigned WIN_N = NUM_BANK * NW * 4;

   localparam logic [CFG_AW-1:0] A_EN   = CFG_AW'(REG_EN);
   localparam logic [CFG_AW-1:0] A_SET  = CFG_AW'(REG_SET);
   localparam logic [CFG_AW-1:0] A_CLR  = CFG_AW'(REG_CLR);
   localparam logic [CFG_AW-1:0] A_WLO  = CFG_AW'(WIN_BASE);
   localparam logic [CFG_AW-1:0] A_WHI  = CFG_AW'(WIN_BASE + WIN_N - 1);

   if ((1 << WB) != NW) begin : g_bad_nw
      $error("mem_fw_regs: NW must be a power of two >= 2");
   end
   if (WIN_BASE + WIN_N > (1 << CFG_AW)) begin : g_bad_aw
      $error("mem_fw_regs: CFG_AW too narrow for the window block");
   end
   if (EN_W > 32) begin : g_bad_en
      $error("mem_fw_regs: enables do not fit one word");
   end
   if (ADDR_W <= 32 || ADDR_W > 64 || GRAN == 0 || GRAN >= 32) begin : g_bad_addr
      $error("mem_fw_regs: unsupported ADDR_W/GRAN");
   end

   logic [EN_W-1:0]                     en_q;
   logic [NUM_BANK-1:0][NW-1:0][PW-1:0] base_q;
   logic [NUM_BANK-1:0][NW-1:0][PW-1:0] lim_q;

   logic               in_win;
   logic               is_en_view;
   logic [IDX_W-1:0]   idx;
   logic               bsel;
   logic [WB-1:0]      wsel;
   win_fld_e           fld;

   assign is_en_view = (cfg_addr == A_EN) || (cfg_addr == A_SET) || (cfg_addr == A_CLR);
   assign in_win     = (cfg_addr >= A_WLO) && (cfg_addr <= A_WHI);
   assign idx        = IDX_W'(cfg_addr - A_WLO);
   assign bsel       = idx[IDX_W-1];
   assign wsel       = idx[WB+1:2];
   assign fld        = win_fld_e'(idx[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         base_q <= '0;
         lim_q  <= '0;
      end else if (cfg_wr) begin
         if (cfg_addr == A_EN) begin
            en_q <= cfg_wdata[EN_W-1:0];
         end else if (cfg_addr == A_SET) begin
            en_q <= en_q | cfg_wdata[EN_W-1:0];
         end else if (cfg_addr == A_CLR) begin
            en_q <= en_q & ~cfg_wdata[EN_W-1:0];
         end else if (in_win) begin
            case (fld)
               FLD_BASE_LO: base_q[bsel][wsel][LO_W-1:0]  <= cfg_wdata[31:GRAN];
               FLD_BASE_HI: base_q[bsel][wsel][PW-1:LO_W] <= cfg_wdata[HI_W-1:0];
               FLD_LIM_LO:  lim_q[bsel][wsel][LO_W-1:0]   <= cfg_wdata[31:GRAN];
               FLD_LIM_HI:  lim_q[bsel][wsel][PW-1:LO_W]  <= cfg_wdata[HI_W-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (is_en_view) begin
         cfg_rdata[EN_W-1:0] = en_q;
      end else if (in_win) begin
         case (fld)
            FLD_BASE_LO: cfg_rdata[31:GRAN]  = base_q[bsel][wsel][LO_W-1:0];
            FLD_BASE_HI: cfg_rdata[HI_W-1:0] = base_q[bsel][wsel][PW-1:LO_W];
            FLD_LIM_LO:  cfg_rdata[31:GRAN]  = lim_q[bsel][wsel][LO_W-1:0];
            FLD_LIM_HI:  cfg_rdata[HI_W-1:0] = lim_q[bsel][wsel][PW-1:LO_W];
            default: ;
         endcase
      end
   end

   assign en_o   = en_q;
   assign base_o = base_q;
   assign lim_o  = lim_q;

endmodule

// File: rtl/mem_fw_gate.sv
module mem_fw_gate
   import mem_fw_pkg::*;
#(
   parameter int unsigned ADDR_W    = 37,
   parameter int unsigned GRAN      = 16,
   parameter int unsigned NUM_WIN   = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CFG_AW    = 7,
   parameter int unsigned LFSR_W    = 32,
   parameter logic [LFSR_W-1:0] LFSR_POLY = 32'h8020_0003,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h1ACE_B00C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rq_valid,
   output logic              rq_ready,
   input  logic [ADDR_W-1:0] rq_addr,
   input  logic              rq_write,
   input  logic              rq_secure,
   input  logic              rq_cpu,
   input  logic [DATA_W-1:0] rq_wdata,
   output logic              tg_valid,
   input  logic              tg_ready,
   output logic [ADDR_W-1:0] tg_addr,
   output logic              tg_write,
   output logic              tg_secure,
   output logic [DATA_W-1:0] tg_wdata,
   output logic              er_valid,
   input  logic              er_ready,
   output logic              er_write,
   output logic [DATA_W-1:0] er_rdata,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata
);

   localparam int unsigned PW   = ADDR_W - GRAN;
   localparam int unsigned EN_W = NUM_BANK * NUM_WIN;
   localparam int unsigned REP  = (DATA_W + LFSR_W - 1) / LFSR_W;

   logic [EN_W-1:0]                          win_en;
   logic [NUM_BANK-1:0][NUM_WIN-1:0][PW-1:0] win_base;
   logic [NUM_BANK-1:0][NUM_WIN-1:0][PW-1:0] win_lim;
   logic [NUM_BANK-1:0]                      bank_hit;
   logic [PW-1:0]                            pg;
   logic                                     hit_sel;
   logic                                     allow;
   logic                                     err_free;
   logic                                     blk_acc;
   logic [LFSR_W-1:0]                        lfsr;
   logic [DATA_W-1:0]                        rnd;
   logic                                     er_valid_q;
   logic                                     er_write_q;
   logic [DATA_W-1:0]                        er_rdata_q;

   mem_fw_regs #(
      .NW     (NUM_WIN),
      .ADDR_W (ADDR_W),
      .GRAN   (GRAN),
      .CFG_AW (CFG_AW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .en_o      (win_en),
      .base_o    (win_base),
      .lim_o     (win_lim)
   );

   assign pg = rq_addr[ADDR_W-1:GRAN];

   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      mem_fw_bank #(
         .NW (NUM_WIN),
         .PW (PW)
      ) u_bank (
         .en   (win_en[b*NUM_WIN +: NUM_WIN]),
         .base (win_base[b]),
         .lim  (win_lim[b]),
         .pg   (pg),
         .hit  (bank_hit[b])
      );
   end

   mem_fw_lfsr #(
      .W    (LFSR_W),
      .POLY (LFSR_POLY),
      .SEED (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr)
   );

   assign rnd = DATA_W'({REP{lfsr}});

   assign hit_sel  = rq_cpu ? bank_hit[BANK_CPU] : bank_hit[BANK_OTHER];
   assign allow    = rq_secure | hit_sel;
   assign err_free = ~er_valid_q | er_ready;
   assign blk_acc  = rq_valid & ~allow & err_free;

   // forward path: combinational, gated by the verdict
   assign tg_valid  = rq_valid & allow;
   assign tg_addr   = rq_addr;
   assign tg_write  = rq_write;
   assign tg_secure = rq_secure;
   assign tg_wdata  = rq_wdata;
   assign rq_ready  = allow ? tg_ready : err_free;

   // local error response slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         er_valid_q <= 1'b0;
         er_write_q <= 1'b0;
         er_rdata_q <= '0;
      end else if (blk_acc) begin
         er_valid_q <= 1'b1;
         er_write_q <= rq_write;
         er_rdata_q <= rq_write ? '0 : rnd;
      end else if (er_ready) begin
         er_valid_q <= 1'b0;
      end
   end

   assign er_valid = er_valid_q;
   assign er_write = er_write_q;
   assign er_rdata = er_rdata_q;

endmodule

// File: rtl/mem_fw_gate_chk.sv
module mem_fw_gate_chk #(
   parameter int unsigned NW     = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CFG_AW = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rq_valid,
   input logic              rq_ready,
   input logic              rq_secure,
   input logic              rq_write,
   input logic              tg_valid,
   input logic              tg_ready,
   input logic              hit_sel,
   input logic              er_valid,
   input logic              er_ready,
   input logic              er_write,
   input logic [DATA_W-1:0] er_rdata,
   input logic              cfg_wr,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [2*NW-1:0]   cfg_wdata,
   input logic [2*NW-1:0]   win_en
);

   a_r5_blocked_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      tg_valid |-> (rq_secure || hit_sel));

   a_r2_secure_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && rq_secure) |-> tg_valid);

   a_r6_error_after_block: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && rq_ready && !tg_valid) |=> (er_valid && er_write == $past(rq_write)));

   a_r6_error_held: assert property (@(posedge clk) disable iff (!rst_n)
      (er_valid && !er_ready) |=> (er_valid && $stable(er_rdata) && $stable(er_write)));

   a_r7_read_data_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (er_valid && !er_write) |-> (er_rdata != '0));

   a_r7_write_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (er_valid && er_write) |-> (er_rdata == '0));

   a_r9_set_ors_in: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == CFG_AW'(1)) |=>
         ((win_en & $past(cfg_wdata)) == $past(cfg_wdata)));

   a_r9_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == CFG_AW'(2)) |=> ((win_en & $past(cfg_wdata)) == '0));

   a_r11_ready_follows_target: assert property (@(posedge clk) disable iff (!rst_n)
      tg_valid |-> (rq_ready == tg_ready));

endmodule

bind mem_fw_gate mem_fw_gate_chk #(
   .NW     (NUM_WIN),
   .DATA_W (DATA_W),
   .CFG_AW (CFG_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rq_valid  (rq_valid),
   .rq_ready  (rq_ready),
   .rq_secure (rq_secure),
   .rq_write  (rq_write),
   .tg_valid  (tg_valid),
   .tg_ready  (tg_ready),
   .hit_sel   (hit_sel),
   .er_valid  (er_valid),
   .er_ready  (er_ready),
   .er_write  (er_write),
   .er_rdata  (er_rdata),
   .cfg_wr    (cfg_wr),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata[2*NUM_WIN-1:0]),
   .win_en    (win_en)
);

// File: tb/mem_fw_gate_tb.sv
module mem_fw_gate_tb;

   typedef struct packed {
      logic [36:0] addr;
      logic        sec;
      logic        cpu;
      logic        wr;
      logic        pass;
   } vec_t;

   // processor bank window 0: pages 0x10..0x1F; other bank window 3: pages 0x100000..0x100003
   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{37'h00_0010_0000, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 base edge
      '{37'h00_001F_FFFF, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 limit inclusive
      '{37'h00_0020_0000, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 one page above
      '{37'h00_000F_FFFF, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 one byte below
      '{37'h00_0010_0000, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 other class, no window
      '{37'h10_0000_0000, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 other bank base
      '{37'h10_0003_FFFF, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 other bank limit
      '{37'h10_0004_0000, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 past limit
      '{37'h10_0000_0000, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 cpu class, wrong bank
      '{37'h00_0020_0000, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 secure outside
      '{37'h1F_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 secure top
      '{37'h00_0015_ABCD, 1'b0, 1'b1, 1'b1, 1'b1}   // R3 low bits ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rq_valid = 1'b0;
   logic        rq_ready;
   logic [36:0] rq_addr = '0;
   logic        rq_write = 1'b0;
   logic        rq_secure = 1'b0;
   logic        rq_cpu = 1'b0;
   logic [31:0] rq_wdata = '0;
   logic        tg_valid;
   logic        tg_ready = 1'b1;
   logic [36:0] tg_addr;
   logic        tg_write;
   logic        tg_secure;
   logic [31:0] tg_wdata;
   logic        er_valid;
   logic        er_ready = 1'b1;
   logic        er_write;
   logic [31:0] er_rdata;
   logic        cfg_wr = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] prev_rnd = '0;

   always #5 clk = ~clk;

   mem_fw_gate u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rq_valid  (rq_valid),
      .rq_ready  (rq_ready),
      .rq_addr   (rq_addr),
      .rq_write  (rq_write),
      .rq_secure (rq_secure),
      .rq_cpu    (rq_cpu),
      .rq_wdata  (rq_wdata),
      .tg_valid  (tg_valid),
      .tg_ready  (tg_ready),
      .tg_addr   (tg_addr),
      .tg_write  (tg_write),
      .tg_secure (tg_secure),
      .tg_wdata  (tg_wdata),
      .er_valid  (er_valid),
      .er_ready  (er_ready),
      .er_write  (er_write),
      .er_rdata  (er_rdata),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_expect(input logic [6:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   // one request with tg_ready=1 and er_ready=1
   task automatic send(input logic [36:0] a, input logic s, input logic c, input logic w,
                       input logic p, input string req);
      @(negedge clk);
      rq_valid = 1'b1; rq_addr = a; rq_secure = s; rq_cpu = c; rq_write = w;
      rq_wdata = a[31:0] ^ 32'h5A5A_0F0F;
      #1;
      check({req, " R5 tg_valid"}, tg_valid, p);
      check({req, " rq_ready"}, rq_ready, 1'b1);
      if (p) begin
         check({req, " R2 fields"}, {tg_addr, tg_write, tg_secure, tg_wdata},
               {a, w, s, a[31:0] ^ 32'h5A5A_0F0F});
      end
      @(negedge clk);
      rq_valid = 1'b0;
      #1;
      check({req, " R6 er_valid"}, er_valid, !p);
      if (!p) begin
         check({req, " R6 er_write"}, er_write, w);
         if (w) begin
            check({req, " R7 write data zero"}, er_rdata, 32'h0);
         end else begin
            check({req, " R7 data nonzero"}, (er_rdata != 32'h0), 1'b1);
            check({req, " R7 data changes"}, (er_rdata != prev_rnd), 1'b1);
            prev_rnd = er_rdata;
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cfg_expect(7'd0, 32'h0, "R1 enables after reset");
      #1 check("R1 no pending error", er_valid, 1'b0);
      send(37'h00_0010_0000, 1'b0, 1'b1, 1'b0, 1'b0, "R1 ns blocked after reset");

      // R8: direct enable register
      cfg_write(7'd0, 32'hFFFF_A5A5);
      cfg_expect(7'd0, 32'h0000_A5A5, "R8 enable readback");
      cfg_write(7'd0, 32'h0);
      cfg_expect(7'd0, 32'h0, "R8 enable cleared by direct write");

      // R10: windows; processor bank window 0 at words 16..19
      cfg_write(7'd16, 32'h0010_FFFF);
      cfg_write(7'd17, 32'h0);
      cfg_write(7'd18, 32'h001F_0000);
      cfg_write(7'd19, 32'h0);
      cfg_expect(7'd16, 32'h0010_0000, "R10 base low, bits 15:0 read 0");
      // other bank window 3 at words 60..63
      cfg_write(7'd60, 32'h0);
      cfg_write(7'd61, 32'h0000_0010);
      cfg_write(7'd62, 32'h0003_0000);
      cfg_write(7'd63, 32'h0000_0010);
      cfg_expect(7'd61, 32'h0000_0010, "R10 base extension");
      cfg_expect(7'd62, 32'h0003_0000, "R10 limit low");

      // R9: set register
      cfg_write(7'd1, 32'h0000_0801);
      cfg_expect(7'd0, 32'h0000_0801, "R9 set ORs bits");
      cfg_write(7'd1, 32'h0);
      cfg_expect(7'd1, 32'h0000_0801, "R9 zero to set no effect");

      // table walk: R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         send(VECS[i].addr, VECS[i].sec, VECS[i].cpu, VECS[i].wr, VECS[i].pass,
              $sformatf("R3/R4 vec%0d", i));
      end

      // R9: clear register
      cfg_write(7'd2, 32'h0000_0001);
      cfg_expect(7'd2, 32'h0000_0800, "R9 clear removes bit");
      cfg_write(7'd2, 32'h0);
      cfg_expect(7'd0, 32'h0000_0800, "R9 zero to clear no effect");
      send(37'h00_0010_0000, 1'b0, 1'b1, 1'b0, 1'b0, "R9 cleared window blocks");

      // R11: backpressure on forwarded path
      @(negedge clk);
      tg_ready = 1'b0;
      rq_valid = 1'b1; rq_addr = 37'h10_0001_0000; rq_secure = 1'b0; rq_cpu = 1'b0; rq_write = 1'b0;
      #1;
      check("R11 tg_valid under stall", tg_valid, 1'b1);
      check("R11 rq_ready follows tg_ready=0", rq_ready, 1'b0);
      tg_ready = 1'b1;
      #1;
      check("R11 rq_ready follows tg_ready=1", rq_ready, 1'b1);
      @(negedge clk);
      rq_valid = 1'b0;

      // R6: held error response and stalled second blocked request
      @(negedge clk);
      er_ready = 1'b0;
      rq_valid = 1'b1; rq_addr = 37'h00_0030_0000; rq_cpu = 1'b1; rq_secure = 1'b0; rq_write = 1'b0;
      #1;
      check("R6 first blocked accepted", rq_ready, 1'b1);
      @(negedge clk);
      rq_addr = 37'h00_0040_0000;
      #1;
      check("R6 error pending", er_valid, 1'b1);
      check("R6 second blocked stalls", rq_ready, 1'b0);
      check("R5 blocked not forwarded", tg_valid, 1'b0);
      held = er_rdata;
      @(negedge clk);
      #1;
      check("R6 response held stable", er_rdata, held);
      check("R6 still valid", er_valid, 1'b1);
      er_ready = 1'b1;
      #1;
      check("R6 accept when taken", rq_ready, 1'b1);
      @(negedge clk);
      rq_valid = 1'b0;
      #1;
      check("R6 second response valid", er_valid, 1'b1);
      check("R7 second data differs", (er_rdata != held), 1'b1);
      @(negedge clk);
      #1;
      check("R6 response drained", er_valid, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule